// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block merges a set of peripheral interrupt lines and one non-maskable line onto the single interrupt input of a processor. Each source line passes through a two-flop synchroniser. Edge-type lines are then reduced to a rising-edge detect, and level-type lines pass as a level. Either kind sets a pending latch that holds the request until it is acknowledged or cleared by software. A masked request is therefore kept, not lost, and is delivered once its gates open.

Each source has a fixed priority set by parameter. Software controls four things: a per-source enable mask, a global enable, a priority threshold, and a write-one-to-clear view of the pending bits. An in-service stack holds the priority of every handler that has been acknowledged and not yet retired. A new request reaches the processor only if its priority is strictly above the level on top of that stack.

The processor reads the winning vector index through the register read port. It then pulses `ack` when it takes the interrupt and pulses `eoi` when the handler returns.

Top module: `irq_nest_ctrl`

## Requirements
- R1: `irq` is high exactly when an eligible pending request exists and the in-service rule allows it. A request that appears on an input after a falling clock edge reaches `irq` after three rising edges.
- R2: Register 0 is the per-source enable mask, with bit i for source i. Register 1 bit 0 is the global enable. A source that is masked, or that arrives while the global enable is 0, does not raise `irq`.
- R3: A request that arrives while it is blocked stays pending: register 3 bit i reads 1. It raises `irq` as soon as it is enabled, including right after the handler that blocked it is retired.
- R4: Register 2 holds a threshold. Only sources whose priority is strictly greater than the threshold are presented.
- R5: While a handler is in service, only a request of strictly higher priority raises `irq`. Requests of equal or lower priority wait until `eoi` retires the handler.
- R6: Among eligible requests, the highest priority wins. On a tie, the lower source index wins. With the default parameters, sources 0 to 7 have priorities 1, 3, 5, 7, 2, 5, 4, 6; sources 0 to 3 are edge-type and sources 4 to 7 are level-type.
- R7: The non-maskable input is edge-type. Its pending state is register 3 bit N (bit 8 by default) and its index is N. It ignores the mask, the global enable and the threshold. It wins over every source and preempts any handler except a non-maskable one already in service. Software cannot clear its pending bit.
- R8: Register 4 reads the vector: bit 15 equals `irq`, and the low bits carry the winning index.
- R9: An `ack` while `irq` is high does three things: it clears the global enable, clears the winner's pending bit, and pushes the winner's level onto the in-service stack. An `ack` while `irq` is low changes nothing.
- R10: An `eoi` pops the stack. The pop that empties the stack ORs back the global-enable value saved at the outermost `ack`. A software write to register 1 in the same cycle takes precedence. An `eoi` on an empty stack changes nothing.
- R11: An edge source sets pending only on a rising edge, so a line held high does not re-pend after `ack`. A level source keeps setting pending while high. Writing 1s to register 3 clears the matching source pending bits.
- R12: After reset, the mask, global enable, threshold and all pending bits read 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | N_SRC | Peripheral request lines |
| nmi_in | input | 1 | Non-maskable request line (edge-type) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | REG_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | REG_W | Register read data (combinational) |
| ack | input | 1 | Interrupt taken strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The properties assume the following about the processor side:
- `eoi` pulses only to retire a handler that was acknowledged earlier.
- Request lines are held for at least two clock cycles, so that the synchroniser sees them.
- `ack` is pulsed only after the vector has been read.

The stimulus keeps within these limits. Every strobe is driven for exactly one cycle, from a falling edge. Every source pulse lasts two cycles. Retire strobes are issued only in the same count as the acknowledges that came before them.

// File: rtl/irq_nest_pkg.sv
`timescale 1ns/1ps
package irq_nest_pkg;
  typedef enum logic [2:0] {
    RA_MASK = 3'd0,
    RA_CTRL = 3'd1,
    RA_THR  = 3'd2,
    RA_PEND = 3'd3,
    RA_VEC  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_src_sync.sv
`timescale 1ns/1ps
module irq_src_sync #(
  parameter int              NP        = 9,
  parameter logic [NP-1:0]   EDGE_MASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] raw,
  output logic [NP-1:0] req
);
  logic [NP-1:0] s1, s2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
    end else begin
      s1   <= raw;
      s2   <= s1;
      prev <= s2;
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_kind
    if (EDGE_MASK[i]) begin : g_edge
      assign req[i] = s2[i] & ~prev[i];
    end else begin : g_level
      assign req[i] = s2[i];
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter int                     N_SRC    = 8,
  parameter int                     PRIO_W   = 3,
  parameter logic [N_SRC*PRIO_W-1:0] SRC_PRIO = '0,
  localparam int                    IDX_W    = $clog2(N_SRC + 1),
  localparam int                    LVL_W    = PRIO_W + 1
) (
  input  logic [N_SRC:0]     pend,
  input  logic [N_SRC-1:0]   mask,
  input  logic               gen_en,
  input  logic [PRIO_W-1:0]  thr,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output logic [LVL_W-1:0]   win_lvl
);
  localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(1 << PRIO_W);

  logic [PRIO_W-1:0] best_p;
  logic [PRIO_W-1:0] p;

  always_comb begin
    win_valid = 1'b0;
    best_p    = '0;
    win_idx   = '0;
    p         = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      p = SRC_PRIO[i*PRIO_W +: PRIO_W];
      if (pend[i] && mask[i] && gen_en && (p > thr) && (!win_valid || p >= best_p)) begin
        win_valid = 1'b1;
        best_p    = p;
        win_idx   = IDX_W'(i);
      end
    end
    win_lvl = {1'b0, best_p};
    if (pend[N_SRC]) begin
      win_valid = 1'b1;
      win_idx   = IDX_W'(N_SRC);
      win_lvl   = NMI_LVL;
    end
  end
endmodule

// File: rtl/irq_isr_stack.sv
`timescale 1ns/1ps
module irq_isr_stack #(
  parameter int  LVL_W = 4,
  parameter int  DEPTH = 9,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LVL_W-1:0] push_lvl,
  output logic [LVL_W-1:0] top_lvl,
  output logic [CNT_W-1:0] depth,
  output logic             empty
);
  logic [LVL_W-1:0] mem [DEPTH];
  logic             do_swap, do_push, do_pop;

  assign empty   = (depth == '0);
  assign do_swap = push && pop && !empty;
  assign do_push = push && !do_swap && (depth < CNT_W'(DEPTH));
  assign do_pop  = pop && !push && !empty;
  assign top_lvl = empty ? '0 : mem[depth - 1'b1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       depth <= '0;
    else if (do_push) depth <= depth + 1'b1;
    else if (do_pop)  depth <= depth - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_swap)      mem[depth - 1'b1] <= push_lvl;
    else if (do_push) mem[depth]        <= push_lvl;
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
`timescale 1ns/1ps
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int                      N_SRC     = 8,
  parameter int                      PRIO_W    = 3,
  parameter logic [N_SRC*PRIO_W-1:0] SRC_PRIO  = 24'hD2AF59,
  parameter logic [N_SRC-1:0]        EDGE_MASK = 8'h0F,
  parameter int                      REG_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_in,
  input  logic              nmi_in,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [2:0]        rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              ack,
  input  logic              eoi,
  output logic              irq
);
  localparam int NP    = N_SRC + 1;
  localparam int IDX_W = $clog2(NP);
  localparam int LVL_W = PRIO_W + 1;
  localparam int DEPTH = (1 << PRIO_W) + 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [NP-1:0]     req, pend, clr;
  logic [N_SRC-1:0]  mask;
  logic [PRIO_W-1:0] thr;
  logic              gen_en, gen_saved;
  logic              win_valid;
  logic [IDX_W-1:0]  win_idx;
  logic [LVL_W-1:0]  win_lvl, top_lvl;
  logic [CNT_W-1:0]  depth;
  logic              stk_empty, take, retire, last_pop;
  logic              wr_mask, wr_ctrl, wr_thr, wr_pend;

  irq_src_sync #(.NP(NP), .EDGE_MASK({1'b1, EDGE_MASK})) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({nmi_in, src_in}), .req(req)
  );

  irq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .SRC_PRIO(SRC_PRIO)) u_arb (
    .pend(pend), .mask(mask), .gen_en(gen_en), .thr(thr),
    .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  irq_isr_stack #(.LVL_W(LVL_W), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(take), .pop(retire), .push_lvl(win_lvl),
    .top_lvl(top_lvl), .depth(depth), .empty(stk_empty)
  );

  assign irq      = win_valid && (stk_empty || (win_lvl > top_lvl));
  assign take     = ack && irq;
  assign retire   = eoi && !stk_empty;
  assign last_pop = retire && !take && (depth == CNT_W'(1));

  assign wr_mask = wr_en && (wr_addr == RA_MASK);
  assign wr_ctrl = wr_en && (wr_addr == RA_CTRL);
  assign wr_thr  = wr_en && (wr_addr == RA_THR);
  assign wr_pend = wr_en && (wr_addr == RA_PEND);

  // clear sources: winner on take, software write-one-to-clear (not the NMI bit)
  for (genvar i = 0; i < NP; i++) begin : g_clr
    if (i < N_SRC) begin : g_src
      assign clr[i] = (take && (win_idx == IDX_W'(i))) || (wr_pend && wr_data[i]);
    end else begin : g_nmi
      assign clr[i] = take && (win_idx == IDX_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask      <= '0;
      thr       <= '0;
      gen_en    <= 1'b0;
      gen_saved <= 1'b0;
    end else begin
      if (wr_mask) mask <= wr_data[N_SRC-1:0];
      if (wr_thr)  thr  <= wr_data[PRIO_W-1:0];
      if (take) begin
        gen_en <= 1'b0;
        if (stk_empty) gen_saved <= gen_en;
      end
      if (last_pop) gen_en <= gen_en | gen_saved;
      if (wr_ctrl)  gen_en <= wr_data[0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_MASK: rd_data[N_SRC-1:0]  = mask;
      RA_CTRL: rd_data[0]          = gen_en;
      RA_THR:  rd_data[PRIO_W-1:0] = thr;
      RA_PEND: rd_data[NP-1:0]     = pend;
      RA_VEC: begin
        rd_data[REG_W-1]   = irq;
        rd_data[IDX_W-1:0] = win_idx;
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
`timescale 1ns/1ps
module irq_nest_ctrl_chk #(
  parameter int                      N_SRC    = 8,
  parameter int                      PRIO_W   = 3,
  parameter logic [N_SRC*PRIO_W-1:0] SRC_PRIO = '0,
  localparam int IDX_W = $clog2(N_SRC + 1),
  localparam int LVL_W = PRIO_W + 1,
  localparam int CNT_W = $clog2((1 << PRIO_W) + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              ack,
  input logic              eoi,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic              gen_en,
  input logic [N_SRC-1:0]  mask,
  input logic [PRIO_W-1:0] thr,
  input logic [N_SRC:0]    pend,
  input logic [IDX_W-1:0]  win_idx,
  input logic [CNT_W-1:0]  depth,
  input logic [LVL_W-1:0]  top_lvl
);
  localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(1 << PRIO_W);

  function automatic logic [PRIO_W-1:0] prio_of(input logic [IDX_W-1:0] k);
    return PRIO_W'(SRC_PRIO >> (k * PRIO_W));
  endfunction

  logic src_win, mask_bit, nmi_busy;
  assign src_win  = (win_idx != IDX_W'(N_SRC));
  assign mask_bit = ((mask >> win_idx) & {{(N_SRC-1){1'b0}}, 1'b1}) != '0;
  assign nmi_busy = (depth != '0) && (top_lvl == NMI_LVL);

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != '0)); // R1
  AST_GATED_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && src_win) |-> (gen_en && mask_bit)); // R2
  AST_ABOVE_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && src_win) |-> (prio_of(win_idx) > thr)); // R4
  AST_STACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && !eoi) |=> (depth == CNT_W'($past(depth) + 1'b1))); // R5
  AST_NMI_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[N_SRC] && !nmi_busy) |-> (irq && !src_win)); // R7
  AST_ACK_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && !(wr_en && wr_addr == 3'd1)) |=> !gen_en); // R9
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(
  .N_SRC(N_SRC), .PRIO_W(PRIO_W), .SRC_PRIO(SRC_PRIO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ack(ack), .eoi(eoi),
  .wr_en(wr_en), .wr_addr(wr_addr), .gen_en(gen_en), .mask(mask), .thr(thr),
  .pend(pend), .win_idx(win_idx), .depth(depth), .top_lvl(top_lvl)
);

// File: tb/irq_nest_ctrl_tb.sv
`timescale 1ns/1ps
module irq_nest_ctrl_tb;
  localparam int N = 8;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src_in = '0;
  logic         nmi_in = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         ack = 1'b0;
  logic         eoi = 1'b0;
  logic         irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irq_nest_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .nmi_in(nmi_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ack(ack), .eoi(eoi), .irq(irq)
  );

  // {sources 3..0 to pulse, mask, threshold, expected irq, expected index}
  localparam logic [19:0] VEC [8] = '{
    {4'h3, 8'hFF, 3'd0, 1'b1, 4'd1},
    {4'hF, 8'hFF, 3'd0, 1'b1, 4'd3},
    {4'hF, 8'h07, 3'd0, 1'b1, 4'd2},
    {4'h5, 8'hFF, 3'd5, 1'b0, 4'd0},
    {4'h5, 8'hFF, 3'd4, 1'b1, 4'd2},
    {4'h1, 8'hFF, 3'd0, 1'b1, 4'd0},
    {4'h8, 8'hF7, 3'd0, 1'b0, 4'd0},
    {4'hA, 8'hFF, 3'd6, 1'b1, 4'd3}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic strobe_ack();
    ack = 1'b1; tick(1); ack = 1'b0;
  endtask

  task automatic strobe_eoi();
    eoi = 1'b1; tick(1); eoi = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] bits);
    src_in = src_in | bits;
    tick(2);
    src_in = src_in & ~bits;
    tick(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [W-1:0] d;
    tick(2);
    // R12 reset state
    check("R12 irq", irq, 0);
    rd(3'd0, d); check("R12 mask", d, 0);
    rd(3'd1, d); check("R12 ctrl", d, 0);
    rd(3'd2, d); check("R12 thr", d, 0);
    rd(3'd3, d); check("R12 pend", d, 0);
    rst_n = 1'b1;
    tick(2);

    // R6 R4 R2 R8 R1: vector walk
    foreach (VEC[k]) begin
      wr(3'd3, 16'h00FF);
      wr(3'd0, {8'h00, VEC[k][15:8]});
      wr(3'd2, {13'd0, VEC[k][7:5]});
      wr(3'd1, 16'h0001);
      pulse({4'h0, VEC[k][19:16]});
      check($sformatf("R6 R4 R1 irq vec%0d", k), irq, VEC[k][4]);
      rd(3'd4, d);
      check($sformatf("R8 valid vec%0d", k), d[15], VEC[k][4]);
      if (VEC[k][4]) check($sformatf("R6 index vec%0d", k), d[3:0], VEC[k][3:0]);
    end
    wr(3'd3, 16'h00FF);
    wr(3'd2, 16'h0000);

    // R1 latency: three rising edges from input to irq
    src_in[3] = 1'b1;
    tick(2); check("R1 not yet", irq, 0);
    tick(1); check("R1 at third edge", irq, 1);
    src_in[3] = 1'b0; tick(2);
    wr(3'd3, 16'h00FF);

    // R6 tie + R9 + R5 + R10 + R3 nesting scenario
    src_in[5] = 1'b1;
    pulse(8'h04);
    rd(3'd4, d); check("R6 tie lower index", d[3:0], 2);
    strobe_ack();
    check("R9 irq after ack", irq, 0);
    rd(3'd1, d); check("R9 gen cleared", d, 0);
    rd(3'd3, d); check("R9 winner pending cleared", d, 16'h0020);
    wr(3'd1, 16'h0001);
    check("R5 equal level waits", irq, 0);
    pulse(8'h08);
    check("R5 higher preempts", irq, 1);
    rd(3'd4, d); check("R5 preempt index", d[3:0], 3);
    strobe_ack();
    strobe_eoi();
    check("R5 still nested", irq, 0);
    rd(3'd1, d); check("R10 inner eoi keeps gen", d, 0);
    strobe_eoi();
    rd(3'd1, d); check("R10 last eoi restores gen", d, 1);
    check("R3 replay after return", irq, 1);
    rd(3'd4, d); check("R3 replay index", d[3:0], 5);
    src_in[5] = 1'b0; tick(3);
    strobe_ack();
    strobe_eoi();
    check("R11 level cleared by ack", irq, 0);
    rd(3'd3, d); check("R11 pend empty", d, 0);

    // R3 masked request kept, R11 write-one-to-clear
    wr(3'd0, 16'h0000);
    pulse(8'h02);
    check("R2 masked no irq", irq, 0);
    rd(3'd3, d); check("R3 masked stays pending", d, 16'h0002);
    wr(3'd0, 16'h0002);
    check("R3 delivered on enable", irq, 1);
    wr(3'd3, 16'h0002);
    check("R11 w1c drops irq", irq, 0);
    rd(3'd3, d); check("R11 w1c pend", d, 0);

    // R11 edge source held high does not re-pend
    wr(3'd0, 16'h00FF);
    src_in[0] = 1'b1;
    tick(3);
    check("R11 edge raises", irq, 1);
    strobe_ack();
    strobe_eoi();
    tick(2);
    rd(3'd3, d); check("R11 held edge no re-pend", d, 0);
    check("R11 held edge no irq", irq, 0);
    src_in[0] = 1'b0; tick(3);

    // R7 NMI bypasses all gates, blocked only by itself
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0007);
    nmi_in = 1'b1; tick(2); nmi_in = 1'b0; tick(2);
    check("R7 nmi irq", irq, 1);
    rd(3'd4, d); check("R7 nmi index", d[3:0], 8);
    wr(3'd3, 16'h0100);
    rd(3'd3, d); check("R7 nmi not sw clearable", d, 16'h0100);
    strobe_ack();
    check("R7 irq after ack", irq, 0);
    nmi_in = 1'b1; tick(2); nmi_in = 1'b0; tick(2);
    check("R7 nmi waits on nmi", irq, 0);
    strobe_eoi();
    check("R7 nmi after eoi", irq, 1);
    strobe_ack();
    strobe_eoi();
    rd(3'd1, d); check("R10 restores saved zero", d, 0);
    wr(3'd2, 16'h0000);

    // R9 ack without irq ignored, R10 eoi on empty ignored
    wr(3'd1, 16'h0001);
    strobe_ack();
    rd(3'd1, d); check("R9 idle ack ignored", d, 1);
    wr(3'd1, 16'h0000);
    strobe_eoi();
    rd(3'd1, d); check("R10 empty eoi ignored", d, 0);

    tick(2);
    finish_run();
  end
endmodule